// File: doc/BRIEF.md
# Two-Thread Functional-Unit Issue Arbiter

This block is the issue stage of an in-order core that runs two hardware threads at once. Each thread owns its own dispatch buffer, and the arbiter sees the first two entries of each buffer. In every cycle it routes as many of those entries as it can to four shared units: two load/store units (LSU0, LSU1) and two ALUs (ALU0, ALU1). It tells each buffer how many entries to pop. Issue outputs are combinational from the current inputs and state. Grant history and miss state change on the rising clock edge.

Besides plain loads, the arbiter accepts a steered load that names exactly one load/store unit. This lets a thread gather loads that are likely to miss onto its own unit. The arbiter also records which load/store unit is tied up by an outstanding cache miss, and which thread caused it. The other thread is then kept out of that unit and sent to the remaining unit instead. When both threads want the same unit, the arbiter rotates priority per unit.

Top module: `dsp_issue_arb`

## Requirements
- R1: The opcode class is 2 bits. 0 is an ALU operation and may issue only to an ALU. 1 is a plain load and may issue to either load/store unit. 2 is a steered load and may issue only to the load/store unit whose index is its steer bit (0 = LSU0, 1 = LSU1). 3 is reserved and never issues.
- R2: An ALU operation takes the lowest-numbered ALU that is free and not yet claimed. A plain load takes the lowest-numbered eligible load/store unit.
- R3: A unit receives at most one instruction per cycle. A unit whose busy input is high receives none.
- R4: Issue is in order within a thread. Entry 1 issues only if entry 0 of the same thread issues in the same cycle. If entry 0 cannot issue, nothing from that thread issues. The pop count equals the number of entries issued.
- R5: When both threads pick the same unit, the thread that was not the last one granted that unit wins. A losing thread takes another eligible unit if one is free.
- R6: A miss pulse on a load/store unit marks that unit as held, with the thread last granted that unit as its owner. While the unit is held, the other thread issues nothing into it but may use the other load/store unit.
- R7: The owner thread of a held unit may keep issuing into it, for example its next steered load.
- R8: A fill pulse releases a held unit, and the unit accepts the other thread from the next cycle on. If a miss and a fill arrive in the same cycle, the unit stays held.
- R9: After reset no unit is held, and thread 0 wins the first contention for every unit.

Unit bit order on all unit vectors: bit 0 = LSU0, bit 1 = LSU1, bit 2 = ALU0, bit 3 = ALU1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hd_vld | input | 2x2 | Buffer-head entry valid, [thread][entry] |
| hd_cls | input | 2x2x2 | Opcode class per entry |
| hd_steer | input | 2x2x1 | Steer index for steered loads |
| unit_busy | input | 4 | Unit cannot accept this cycle |
| lsu_miss | input | 2 | Load in this load/store unit missed |
| lsu_fill | input | 2 | Miss on this load/store unit resolved |
| iss_vld | output | 4 | Instruction issued to unit |
| iss_thr | output | 4 | Thread tag of the issued instruction |
| iss_slot | output | 4x1 | Buffer entry index the instruction came from |
| pop_cnt | output | 2x2 | Entries to pop per thread |

## Verification
The hardest state to reach is a held load/store unit whose owner and contender differ. This needs a grant to one thread, then a miss pulse, then requests from both threads in the same cycle. The release edge is equally hard: a fill pulse that arrives in the same cycle as a miss, or in the same cycle as the waiting thread's request. The directed tasks build these sequences cycle by cycle from reset. Because of that, the owner recorded in the grant history and the rotating priority are known values when each check is made.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
    // Thread logic assumes two hardware threads (1-bit thread tag).
    localparam int NUM_THR   = 2;
    localparam int NUM_LSU   = 2;
    localparam int NUM_ALU   = 2;
    localparam int HEADS     = 2;
    localparam int NUM_UNITS = NUM_LSU + NUM_ALU;
    localparam int STEER_W   = (NUM_LSU > 1) ? $clog2(NUM_LSU) : 1;
    localparam int SLOT_W    = (HEADS > 1) ? $clog2(HEADS) : 1;
    localparam int POP_W     = $clog2(HEADS + 1);

    typedef enum logic [1:0] {
        OPC_ALU        = 2'd0,
        OPC_LOAD       = 2'd1,
        OPC_LOAD_STEER = 2'd2,
        OPC_NONE       = 2'd3
    } op_class_e;

    typedef logic [NUM_UNITS-1:0] unit_mask_t;

    typedef struct packed {
        logic              vld;
        logic              thr;
        logic [SLOT_W-1:0] slot;
    } issue_t;

    // isolate the lowest set bit of a unit mask
    function automatic unit_mask_t lowest_bit(input unit_mask_t m);
        return m & (~m + unit_mask_t'(1));
    endfunction
endpackage

// File: rtl/dsp_cand_mask.sv
module dsp_cand_mask
    import dsp_pkg::*;
(
    input  op_class_e          cls,
    input  logic [STEER_W-1:0] steer,
    input  unit_mask_t         avail,
    output unit_mask_t         cand
);
    unit_mask_t kind;

    always_comb begin
        kind = '0;
        case (cls)
            OPC_ALU:        kind[NUM_UNITS-1:NUM_LSU] = '1;
            OPC_LOAD:       kind[NUM_LSU-1:0] = '1;
            OPC_LOAD_STEER: begin
                if (int'(steer) < NUM_LSU) kind[steer] = 1'b1;
            end
            default:        kind = '0;
        endcase
        cand = kind & avail;
    end
endmodule

// File: rtl/dsp_unit_state.sv
module dsp_unit_state
    import dsp_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  issue_t [NUM_UNITS-1:0]     iss,
    input  logic [NUM_LSU-1:0]         miss,
    input  logic [NUM_LSU-1:0]         fill,
    output logic [NUM_UNITS-1:0]       last_thr,
    output logic [NUM_LSU-1:0]         held,
    output logic [NUM_LSU-1:0]         held_thr
);
    genvar u;
    generate
        for (u = 0; u < NUM_UNITS; u++) begin : g_last
            // reset to thread 1 so that thread 0 wins first contention
            always_ff @(posedge clk) begin
                if (rst)             last_thr[u] <= 1'b1;
                else if (iss[u].vld) last_thr[u] <= iss[u].thr;
            end
        end
        for (u = 0; u < NUM_LSU; u++) begin : g_held
            always_ff @(posedge clk) begin
                if (rst) begin
                    held[u]     <= 1'b0;
                    held_thr[u] <= 1'b0;
                end else if (miss[u]) begin
                    held[u]     <= 1'b1;
                    held_thr[u] <= last_thr[u];
                end else if (fill[u]) begin
                    held[u]     <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/dsp_alloc.sv
module dsp_alloc
    import dsp_pkg::*;
(
    input  logic [NUM_THR-1:0][HEADS-1:0] vld,
    input  unit_mask_t [NUM_THR-1:0][HEADS-1:0] cand,
    input  logic [NUM_UNITS-1:0]          last_thr,
    output issue_t [NUM_UNITS-1:0]        iss,
    output logic [NUM_THR-1:0][POP_W-1:0] pop
);
    unit_mask_t taken;
    unit_mask_t pick0;
    unit_mask_t pick1;
    unit_mask_t clash;
    logic       go0;
    logic       go1;
    logic       t0_wins;

    always_comb begin
        taken   = '0;
        go0     = 1'b1;
        go1     = 1'b1;
        pick0   = '0;
        pick1   = '0;
        clash   = '0;
        t0_wins = 1'b0;
        iss     = '0;
        pop     = '0;
        for (int k = 0; k < HEADS; k++) begin
            pick0 = (go0 && vld[0][k]) ? lowest_bit(cand[0][k] & ~taken) : '0;
            pick1 = (go1 && vld[1][k]) ? lowest_bit(cand[1][k] & ~taken) : '0;
            clash = pick0 & pick1;
            if (clash != '0) begin
                // thread 0 wins when thread 1 was last granted the unit
                t0_wins = |(clash & last_thr);
                if (t0_wins) pick1 = lowest_bit(cand[1][k] & ~taken & ~clash);
                else         pick0 = lowest_bit(cand[0][k] & ~taken & ~clash);
            end
            go0 = go0 && (pick0 != '0);
            go1 = go1 && (pick1 != '0);
            for (int u = 0; u < NUM_UNITS; u++) begin
                if (pick0[u]) iss[u] = '{vld: 1'b1, thr: 1'b0, slot: SLOT_W'(k)};
                if (pick1[u]) iss[u] = '{vld: 1'b1, thr: 1'b1, slot: SLOT_W'(k)};
            end
            if (pick0 != '0) pop[0] = pop[0] + POP_W'(1);
            if (pick1 != '0) pop[1] = pop[1] + POP_W'(1);
            taken = taken | pick0 | pick1;
        end
    end
endmodule

// File: rtl/dsp_issue_arb.sv
module dsp_issue_arb
    import dsp_pkg::*;
(
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic [NUM_THR-1:0][HEADS-1:0]             hd_vld,
    input  logic [NUM_THR-1:0][HEADS-1:0][1:0]        hd_cls,
    input  logic [NUM_THR-1:0][HEADS-1:0][STEER_W-1:0] hd_steer,
    input  logic [NUM_UNITS-1:0]                      unit_busy,
    input  logic [NUM_LSU-1:0]                        lsu_miss,
    input  logic [NUM_LSU-1:0]                        lsu_fill,
    output logic [NUM_UNITS-1:0]                      iss_vld,
    output logic [NUM_UNITS-1:0]                      iss_thr,
    output logic [NUM_UNITS-1:0][SLOT_W-1:0]          iss_slot,
    output logic [NUM_THR-1:0][POP_W-1:0]             pop_cnt
);
    logic [NUM_UNITS-1:0]          last_thr;
    logic [NUM_LSU-1:0]            held;
    logic [NUM_LSU-1:0]            held_thr;
    unit_mask_t [NUM_THR-1:0]      avail;
    unit_mask_t [NUM_THR-1:0][HEADS-1:0] cand;
    issue_t [NUM_UNITS-1:0]        iss;

    // units a thread may use: not busy, not held by the other thread's miss
    always_comb begin
        for (int t = 0; t < NUM_THR; t++) begin
            avail[t] = ~unit_busy;
            for (int l = 0; l < NUM_LSU; l++) begin
                if (held[l] && (held_thr[l] != t[0])) avail[t][l] = 1'b0;
            end
        end
    end

    genvar gt, gk;
    generate
        for (gt = 0; gt < NUM_THR; gt++) begin : g_thr
            for (gk = 0; gk < HEADS; gk++) begin : g_ent
                dsp_cand_mask u_cand (
                    .cls   (op_class_e'(hd_cls[gt][gk])),
                    .steer (hd_steer[gt][gk]),
                    .avail (avail[gt]),
                    .cand  (cand[gt][gk])
                );
            end
        end
    endgenerate

    dsp_alloc u_alloc (
        .vld      (hd_vld),
        .cand     (cand),
        .last_thr (last_thr),
        .iss      (iss),
        .pop      (pop_cnt)
    );

    dsp_unit_state u_state (
        .clk      (clk),
        .rst      (rst),
        .iss      (iss),
        .miss     (lsu_miss),
        .fill     (lsu_fill),
        .last_thr (last_thr),
        .held     (held),
        .held_thr (held_thr)
    );

    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++) begin
            iss_vld[u]  = iss[u].vld;
            iss_thr[u]  = iss[u].thr;
            iss_slot[u] = iss[u].slot;
        end
    end
endmodule

// File: rtl/dsp_issue_arb_chk.sv
module dsp_issue_arb_chk
    import dsp_pkg::*;
(
    input logic                                       clk,
    input logic                                       rst,
    input logic [NUM_THR-1:0][HEADS-1:0][1:0]         hd_cls,
    input logic [NUM_THR-1:0][HEADS-1:0][STEER_W-1:0] hd_steer,
    input logic [NUM_UNITS-1:0]                       unit_busy,
    input logic [NUM_LSU-1:0]                         lsu_miss,
    input logic [NUM_LSU-1:0]                         lsu_fill,
    input logic [NUM_UNITS-1:0]                       iss_vld,
    input logic [NUM_UNITS-1:0]                       iss_thr,
    input logic [NUM_UNITS-1:0][SLOT_W-1:0]           iss_slot,
    input logic [NUM_THR-1:0][POP_W-1:0]              pop_cnt,
    input logic [NUM_LSU-1:0]                         held,
    input logic [NUM_LSU-1:0]                         held_thr
);
    logic [NUM_THR-1:0] head_went;
    logic [NUM_UNITS-1:0] own0;
    always_comb begin
        head_went = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (iss_vld[u] && iss_slot[u] == '0) head_went[iss_thr[u]] = 1'b1;
        end
        own0 = iss_vld & ~iss_thr;
    end

    genvar u;
    generate
        for (u = 0; u < NUM_UNITS; u++) begin : g_u
            AST_BUSY_IDLE: assert property (@(posedge clk) disable iff (rst)
                iss_vld[u] |-> !unit_busy[u]);                                  // R3
            AST_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
                (iss_vld[u] && iss_slot[u] != '0) |-> head_went[iss_thr[u]]);  // R4
            AST_STEER_TARGET: assert property (@(posedge clk) disable iff (rst)
                (iss_vld[u] && hd_cls[iss_thr[u]][iss_slot[u]] == OPC_LOAD_STEER)
                |-> (u == int'(hd_steer[iss_thr[u]][iss_slot[u]])));           // R1
        end
        for (u = NUM_LSU + 1; u < NUM_UNITS; u++) begin : g_alu
            AST_ALU_LOW_FIRST: assert property (@(posedge clk) disable iff (rst)
                iss_vld[u] |-> (iss_vld[u-1] || unit_busy[u-1]));               // R2
        end
        for (u = 0; u < NUM_LSU; u++) begin : g_lsu
            AST_HELD_OWNER: assert property (@(posedge clk) disable iff (rst)
                (iss_vld[u] && held[u]) |-> (iss_thr[u] == held_thr[u]));      // R6
            AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (rst)
                ($past(lsu_miss[u]) && !$past(rst)) |-> held[u]);               // R8
            AST_FILL_FREES: assert property (@(posedge clk) disable iff (rst)
                ($past(lsu_fill[u]) && !$past(lsu_miss[u]) && !$past(rst)) |-> !held[u]); // R8
        end
    endgenerate

    AST_POP_T0: assert property (@(posedge clk) disable iff (rst)
        int'(pop_cnt[0]) == $countones(own0));                                  // R4
    AST_POP_T1: assert property (@(posedge clk) disable iff (rst)
        int'(pop_cnt[1]) == $countones(iss_vld & iss_thr));                     // R4
endmodule

bind dsp_issue_arb dsp_issue_arb_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .hd_cls    (hd_cls),
    .hd_steer  (hd_steer),
    .unit_busy (unit_busy),
    .lsu_miss  (lsu_miss),
    .lsu_fill  (lsu_fill),
    .iss_vld   (iss_vld),
    .iss_thr   (iss_thr),
    .iss_slot  (iss_slot),
    .pop_cnt   (pop_cnt),
    .held      (held),
    .held_thr  (held_thr)
);

// File: tb/dsp_issue_arb_tb_top.sv
`timescale 1ns/1ps
module dsp_issue_arb_tb_top;
    import dsp_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NUM_THR-1:0][HEADS-1:0]              hd_vld;
    logic [NUM_THR-1:0][HEADS-1:0][1:0]         hd_cls;
    logic [NUM_THR-1:0][HEADS-1:0][STEER_W-1:0] hd_steer;
    logic [NUM_UNITS-1:0]                       unit_busy;
    logic [NUM_LSU-1:0]                         lsu_miss;
    logic [NUM_LSU-1:0]                         lsu_fill;
    logic [NUM_UNITS-1:0]                       iss_vld;
    logic [NUM_UNITS-1:0]                       iss_thr;
    logic [NUM_UNITS-1:0][SLOT_W-1:0]           iss_slot;
    logic [NUM_THR-1:0][POP_W-1:0]              pop_cnt;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    dsp_issue_arb dut_i (
        .clk(clk), .rst(rst), .hd_vld(hd_vld), .hd_cls(hd_cls), .hd_steer(hd_steer),
        .unit_busy(unit_busy), .lsu_miss(lsu_miss), .lsu_fill(lsu_fill),
        .iss_vld(iss_vld), .iss_thr(iss_thr), .iss_slot(iss_slot), .pop_cnt(pop_cnt)
    );

    task automatic idle();
        hd_vld = '0; hd_cls = '0; hd_steer = '0;
        unit_busy = '0; lsu_miss = '0; lsu_fill = '0;
    endtask

    task automatic set_hd(input int t, input int k, input int c, input int s);
        hd_vld[t][k]   = 1'b1;
        hd_cls[t][k]   = 2'(c);
        hd_steer[t][k] = STEER_W'(s);
    endtask

    // commit the current inputs at the clock edge, return to the falling edge, clear inputs
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // unit bits: 0 LSU0, 1 LSU1, 2 ALU0, 3 ALU1
    task automatic expect_iss(input string req, input int ev, input int et, input int es,
                              input int p0, input int p1);
        logic [NUM_UNITS-1:0] sl;
        #1;
        for (int u = 0; u < NUM_UNITS; u++) sl[u] = iss_slot[u][0];
        chk(req, "vld",  int'(iss_vld), ev);
        chk(req, "thr",  int'(iss_thr & NUM_UNITS'(ev)), et);
        chk(req, "slot", int'(sl & NUM_UNITS'(ev)), es);
        chk(req, "pop0", int'(pop_cnt[0]), p0);
        chk(req, "pop1", int'(pop_cnt[1]), p1);
    endtask

    task automatic t_reset_and_rr();
        do_reset();
        expect_iss("R9 idle", 0, 0, 0, 0, 0);
        set_hd(0, 0, 2, 0); set_hd(1, 0, 2, 0);
        expect_iss("R9 first contention thread0", 4'b0001, 4'b0000, 0, 1, 0);
        step();
        set_hd(0, 0, 2, 0); set_hd(1, 0, 2, 0);
        expect_iss("R5 rotate to thread1", 4'b0001, 4'b0001, 0, 0, 1);
        step();
        set_hd(0, 0, 2, 0); set_hd(1, 0, 2, 0);
        expect_iss("R5 rotate back thread0", 4'b0001, 4'b0000, 0, 1, 0);
        step();
        set_hd(0, 0, 1, 0); set_hd(1, 0, 1, 0);
        expect_iss("R5 loser takes other LSU", 4'b0011, 4'b0001, 0, 1, 1);
        step();
    endtask

    task automatic t_alu();
        do_reset();
        set_hd(0, 0, 0, 0); set_hd(0, 1, 0, 0);
        expect_iss("R2 two ALU ops", 4'b1100, 0, 4'b1000, 2, 0);
        step();
        set_hd(0, 0, 0, 0); set_hd(0, 1, 0, 0); unit_busy = 4'b0100;
        expect_iss("R3 busy ALU0 skipped", 4'b1000, 0, 0, 1, 0);
        step();
        set_hd(0, 0, 0, 0); unit_busy = 4'b1100;
        expect_iss("R3 all ALUs busy", 0, 0, 0, 0, 0);
        step();
        set_hd(0, 0, 0, 0); set_hd(0, 1, 0, 0); set_hd(1, 0, 0, 0);
        expect_iss("R3 one per unit", 4'b1100, 4'b0100, 0, 1, 1);
        step();
    endtask

    task automatic t_route();
        do_reset();
        set_hd(0, 0, 2, 1); set_hd(0, 1, 1, 0);
        expect_iss("R1 steered then plain", 4'b0011, 0, 4'b0001, 2, 0);
        step();
        set_hd(1, 0, 3, 0); set_hd(1, 1, 0, 0);
        set_hd(0, 0, 2, 0); set_hd(0, 1, 0, 0); unit_busy = 4'b0001;
        expect_iss("R4 blocked heads stop threads", 0, 0, 0, 0, 0);
        step();
    endtask

    task automatic t_miss();
        do_reset();
        set_hd(0, 0, 2, 0);
        expect_iss("R6 owner grant", 4'b0001, 0, 0, 1, 0);
        step();
        lsu_miss = 2'b01;
        expect_iss("R6 miss cycle idle", 0, 0, 0, 0, 0);
        step();
        set_hd(1, 0, 2, 0); set_hd(1, 1, 0, 0); set_hd(0, 0, 0, 0);
        expect_iss("R6 other thread kept out", 4'b0100, 0, 0, 1, 0);
        step();
        set_hd(1, 0, 1, 0);
        expect_iss("R6 plain load to free LSU", 4'b0010, 4'b0010, 0, 0, 1);
        step();
        set_hd(0, 0, 2, 0); set_hd(0, 1, 2, 0);
        expect_iss("R7 owner issues into held", 4'b0001, 0, 0, 1, 0);
        step();
        set_hd(1, 0, 2, 0); lsu_fill = 2'b01;
        expect_iss("R8 fill cycle still held", 0, 0, 0, 0, 0);
        step();
        set_hd(1, 0, 2, 0);
        expect_iss("R8 released next cycle", 4'b0001, 4'b0001, 0, 0, 1);
        step();
    endtask

    task automatic t_miss_fill_same();
        do_reset();
        set_hd(1, 0, 2, 1);
        expect_iss("R6 thread1 grant LSU1", 4'b0010, 4'b0010, 0, 0, 1);
        step();
        lsu_miss = 2'b10;
        step();
        lsu_miss = 2'b10; lsu_fill = 2'b10;
        step();
        set_hd(0, 0, 2, 1); set_hd(1, 0, 2, 1);
        expect_iss("R8 miss wins over fill", 4'b0010, 4'b0010, 0, 0, 1);
        step();
        lsu_fill = 2'b10;
        step();
        set_hd(0, 0, 2, 1);
        expect_iss("R8 thread0 after fill", 4'b0010, 0, 0, 1, 0);
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        idle();
        t_reset_and_rr();
        t_alu();
        t_route();
        t_miss();
        t_miss_fill_same();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule